// File: doc/BRIEF.md
# One-Time-Programmable Word Memory with Mode Control

This block models a word-wide memory whose cells can be programmed once and are otherwise read-only. It is driven by three active-low strobes (chip select, output gate and program strobe), a flag that says the high programming supply is present, and a flag that says the identification voltage is applied to address bit 9. From these it decodes seven modes: standby, program inhibit, output off, program, read, verify and identification. It drives a 16-bit data word together with an enable for an external tri-state bus.

All inputs are sampled on the rising clock edge, and the data and drive enable are registered. A read therefore shows up one cycle after the inputs that request it. A program operation commits when the program strobe returns high, provided the chip is selected and the supply is present at that edge. The stored word becomes the old word ANDed with the input data, so a programmed zero can never return to one. Reset stands in for erasure and sets every cell to one.

The full part holds 65,536 words. The number of words is a parameter, and the address is decoded on its low log2(depth) bits only, so a reduced depth can be used in simulation.

Top module: `otp_mode_ctrl`

## Requirements
- R1: During reset and in the first cycle after it, the drive enable is low. After reset every word reads 0xFFFF.
- R2: With chip select low, output gate low, program strobe high and both flags low, the block drives the addressed word one cycle later with the drive enable high.
- R3: With chip select high, the drive enable is low one cycle later, whatever the state of the other inputs.
- R4: With chip select low, the drive enable is low one cycle later in two cases: the output gate is high, or the program strobe is low while the supply flag is low.
- R5: With chip select low, supply flag high and program strobe low, the block is in program mode and does not drive. The program commits at the first clock edge where the strobe is seen high after being seen low, if chip select is low and the supply flag is high at that edge. It uses the address and data of that edge, and the new word is the old word AND the input data.
- R6: A bit that reads 0 stays 0 after any later program of its word, including one with all-ones data.
- R7: A strobe that is low or rises while chip select is high changes no word. This is program inhibit.
- R8: With chip select low, output gate low, program strobe high and supply flag high, the block is in verify mode and returns the stored word. The identification flag has no effect in this mode.
- R9: With read conditions, supply flag low and identification flag high, the output is 0x0020 if address bit 0 is 0 and 0x008C if it is 1. The upper 8 bits are zero and the other address bits are ignored.
- R10: Words are selected by address bits [log2(DEPTH)-1:0] and higher bits are ignored. The last word, DEPTH-1, can be programmed and read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; erases every word to all ones |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output gate, active low |
| pgm_n | input | 1 | Program strobe, active low |
| vpp_on | input | 1 | Programming supply present |
| id_hv | input | 1 | Identification voltage present on address bit 9 |
| addr | input | ADDR_W (16) | Word address |
| din | input | 16 | Data to program |
| dout | output | 16 | Registered output word |
| dout_en | output | 1 | Drive enable for the tri-state data bus |

## Verification
On every cycle the assertions check the mapping from the previous cycle's strobes and flags to the drive enable. This covers no drive with chip select high, with the output gate high, or during a program pulse, and a forced drive in read and verify. They also check the two fixed identification codes against address bit 0. Array contents can only be shown by the bench's scenarios, which cover:
- the AND-only write and the refusal to set a cleared bit;
- strobes that are ignored under inhibit or when chip select rises before the strobe does;
- the identification flag being ignored under the programming supply;
- address aliasing above the configured depth.

// File: rtl/otp_pkg.sv
package otp_pkg;
    localparam int WORD_W = 16;
    localparam logic [7:0] MAKER_ID = 8'h20;
    localparam logic [7:0] PART_ID  = 8'h8C;

    typedef enum logic [2:0] {
        MD_STANDBY,
        MD_INHIBIT,
        MD_OUT_OFF,
        MD_PROGRAM,
        MD_READ,
        MD_VERIFY,
        MD_IDENT
    } mode_e;

    typedef struct packed {
        logic              strobe_low;
        logic              drive;
        logic [WORD_W-1:0] word;
    } ctl_s;
endpackage

// File: rtl/otp_mode_decode.sv
module otp_mode_decode
    import otp_pkg::*;
(
    input  logic  ce_n,
    input  logic  oe_n,
    input  logic  pgm_n,
    input  logic  vpp_on,
    input  logic  id_hv,
    output mode_e mode
);
    always_comb begin
        if (ce_n) begin
            mode = vpp_on ? MD_INHIBIT : MD_STANDBY;
        end else if (!pgm_n && vpp_on) begin
            mode = MD_PROGRAM;
        end else if (oe_n || !pgm_n) begin
            mode = MD_OUT_OFF;
        end else if (vpp_on) begin
            mode = MD_VERIFY;
        end else if (id_hv) begin
            mode = MD_IDENT;
        end else begin
            mode = MD_READ;
        end
    end
endmodule

// File: rtl/otp_id_rom.sv
module otp_id_rom
    import otp_pkg::*;
(
    input  logic              sel,
    output logic [WORD_W-1:0] code
);
    always_comb begin
        code = '0;
        code[7:0] = sel ? PART_ID : MAKER_ID;
    end
endmodule

// File: rtl/otp_cell_array.sv
module otp_cell_array
    import otp_pkg::*;
#(
    parameter int DEPTH = 512,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_mask,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_word
);
    logic [WORD_W-1:0] cells_q [DEPTH];
    logic [WORD_W-1:0] word_d;

    // only ones may be cleared: merge the new data into the old word
    always_comb begin
        word_d  = cells_q[wr_idx] & wr_mask;
        rd_word = cells_q[rd_idx];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                cells_q[i] <= '1;
            end
        end else if (wr_en) begin
            cells_q[wr_idx] <= word_d;
        end
    end
endmodule

// File: rtl/otp_mode_ctrl.sv
module otp_mode_ctrl
    import otp_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DEPTH  = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              pgm_n,
    input  logic              vpp_on,
    input  logic              id_hv,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] dout,
    output logic              dout_en
);
    localparam int IDX_W = $clog2(DEPTH);

    mode_e             mode;
    ctl_s              ctl_d, ctl_q;
    logic [IDX_W-1:0]  idx;
    logic [WORD_W-1:0] cell_word;
    logic [WORD_W-1:0] id_word;
    logic              commit;

    assign idx = addr[IDX_W-1:0];

    generate
        if (IDX_W < ADDR_W) begin : g_hi_unused
            logic unused_hi;
            assign unused_hi = ^addr[ADDR_W-1:IDX_W];
        end
    endgenerate

    otp_mode_decode u_dec (
        .ce_n   (ce_n),
        .oe_n   (oe_n),
        .pgm_n  (pgm_n),
        .vpp_on (vpp_on),
        .id_hv  (id_hv),
        .mode   (mode)
    );

    otp_id_rom u_id (
        .sel  (addr[0]),
        .code (id_word)
    );

    // strobe seen low last edge, high now, with selection and supply held
    assign commit = ctl_q.strobe_low && pgm_n && !ce_n && vpp_on;

    otp_cell_array #(.DEPTH(DEPTH)) u_arr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (commit),
        .wr_idx  (idx),
        .wr_mask (din),
        .rd_idx  (idx),
        .rd_word (cell_word)
    );

    always_comb begin
        ctl_d            = ctl_q;
        ctl_d.strobe_low = !pgm_n;
        unique case (mode)
            MD_READ, MD_VERIFY: begin
                ctl_d.drive = 1'b1;
                ctl_d.word  = cell_word;
            end
            MD_IDENT: begin
                ctl_d.drive = 1'b1;
                ctl_d.word  = id_word;
            end
            default: begin
                ctl_d.drive = 1'b0;
                ctl_d.word  = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign dout    = ctl_q.word;
    assign dout_en = ctl_q.drive;
endmodule

// File: rtl/otp_mode_ctrl_chk.sv
module otp_mode_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        ce_n,
    input logic        oe_n,
    input logic        pgm_n,
    input logic        vpp_on,
    input logic        id_hv,
    input logic        addr_lsb,
    input logic [15:0] dout,
    input logic        dout_en
);
    logic live_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) live_q <= 1'b0;
        else        live_q <= 1'b1;
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !live_q |-> !dout_en);

    // R3
    deselect_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        live_q && $past(ce_n) |-> !dout_en);

    // R4
    gate_off_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        live_q && $past(!ce_n && oe_n) |-> !dout_en);

    // R4
    no_supply_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        live_q && $past(!ce_n && !pgm_n && !vpp_on) |-> !dout_en);

    // R5
    program_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        live_q && $past(!ce_n && !pgm_n && vpp_on) |-> !dout_en);

    // R2
    read_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        live_q && $past(!ce_n && !oe_n && pgm_n) |-> dout_en);

    // R9
    maker_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        live_q && $past(!ce_n && !oe_n && pgm_n && !vpp_on && id_hv && !addr_lsb)
        |-> dout == 16'h0020);

    // R9
    part_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        live_q && $past(!ce_n && !oe_n && pgm_n && !vpp_on && id_hv && addr_lsb)
        |-> dout == 16'h008C);
endmodule

bind otp_mode_ctrl otp_mode_ctrl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce_n     (ce_n),
    .oe_n     (oe_n),
    .pgm_n    (pgm_n),
    .vpp_on   (vpp_on),
    .id_hv    (id_hv),
    .addr_lsb (addr[0]),
    .dout     (dout),
    .dout_en  (dout_en)
);

// File: tb/tb_otp_mode_ctrl.sv
module tb_otp_mode_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 16;
    localparam int DEPTH  = 512;
    localparam int IDX_W  = $clog2(DEPTH);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b1, oe_n = 1'b1, pgm_n = 1'b1, vpp_on = 1'b0, id_hv = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [15:0] din = '0;
    logic [15:0] dout;
    logic dout_en;

    int n_checks = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    otp_mode_ctrl #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .pgm_n(pgm_n),
        .vpp_on(vpp_on), .id_hv(id_hv), .addr(addr), .din(din),
        .dout(dout), .dout_en(dout_en)
    );

    typedef struct {
        bit          en;
        logic [15:0] data;
        string       tag;
    } exp_t;

    exp_t        sbq[$];
    exp_t        got;
    logic [15:0] model [DEPTH];
    logic        model_strobe_low;

    // monitor: compares one registered result per clock
    always @(posedge clk) begin
        #1;
        if (sbq.size() > 0) begin
            got = sbq.pop_front();
            n_checks++;
            if (dout_en !== got.en || (got.en && dout !== got.data)) begin
                n_fail++;
                $display("FAIL %s: got en=%0b data=%h, expected en=%0b data=%h",
                         got.tag, dout_en, dout, got.en, got.data);
            end
        end
    end

    // driver: applies one cycle of stimulus and queues the expected output
    task automatic drv(input logic c, input logic o, input logic p, input logic v,
                       input logic i, input logic [ADDR_W-1:0] a,
                       input logic [15:0] d, input string tag);
        exp_t e;
        logic [IDX_W-1:0] k;
        @(negedge clk);
        ce_n = c; oe_n = o; pgm_n = p; vpp_on = v; id_hv = i; addr = a; din = d;
        k = a[IDX_W-1:0];
        e.tag = tag;
        e.data = '0;
        if (c || (!p && v) || o || !p) begin
            e.en = 1'b0;
        end else if (i && !v) begin
            e.en = 1'b1;
            e.data = a[0] ? 16'h008C : 16'h0020;
        end else begin
            e.en = 1'b1;
            e.data = model[k];
        end
        if (model_strobe_low && p && !c && v) model[k] = model[k] & d;
        model_strobe_low = !p;
        sbq.push_back(e);
    endtask

    task automatic prog(input logic [ADDR_W-1:0] a, input logic [15:0] d, input string tag);
        drv(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, a, d, tag);
        drv(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, a, d, tag);
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, input string tag);
        drv(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, a, 16'h0, tag);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int j = 0; j < DEPTH; j++) model[j] = 16'hFFFF;
        model_strobe_low = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_checks++;
        if (dout_en !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 reset: got en=%0b, expected en=0", dout_en);
        end
        rst_n = 1'b1;

        drv(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0, 16'h0, "R1 idle after reset");
        rd(16'h0005, "R1 erased word");
        rd(16'h0000, "R2 read word 0");

        prog(16'h0005, 16'hA5A5, "R5 program cycle");
        drv(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 16'h0005, 16'h0, "R8 verify");
        rd(16'h0005, "R2 read programmed");
        prog(16'h0005, 16'hFFFF, "R6 all-ones program");
        rd(16'h0005, "R6 cleared bits stay");
        prog(16'h0005, 16'h0F0F, "R5 AND merge");
        rd(16'h0005, "R5 merged word");

        drv(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 16'h0007, 16'h0000, "R7 inhibit low");
        drv(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 16'h0007, 16'h0000, "R7 inhibit rise");
        drv(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0007, 16'h0000, "R3 gate low deselected");
        rd(16'h0007, "R7 word untouched");

        drv(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 16'h0008, 16'h0000, "R5 strobe low");
        drv(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 16'h0008, 16'h0000, "R7 rise after deselect");
        rd(16'h0008, "R7 no commit");

        drv(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0005, 16'h0, "R4 gate high");
        drv(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0005, 16'h0, "R4 strobe low no supply");
        rd(16'h0005, "R4 strobe without supply wrote nothing");

        drv(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 16'h0000, 16'h0, "R9 maker code");
        drv(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 16'h0001, 16'h0, "R9 part code");
        drv(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 16'hFFF4, 16'h0, "R9 other bits ignored");
        drv(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 16'h0005, 16'h0, "R8 id flag under supply");

        prog(16'(DEPTH-1), 16'h1234, "R10 program last word");
        rd(16'(DEPTH-1), "R10 read last word");
        rd(16'(DEPTH-1) | 16'h8000, "R10 high bits ignored");
        rd(16'(DEPTH-2), "R10 neighbour erased");

        @(negedge clk);
        drv(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0, 16'h0, "R3 final idle");
        @(posedge clk);
        #2;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule